// File: doc/BRIEF.md
# ALU Status Flag Generator

This block derives the six arithmetic status flags of a 32-bit integer operation. The datapath supplies both operands, a three-bit operation code and the result it produced. The block returns the flags at once on a combinational output. It also holds them in a flags register that software can modify one bit at a time.

Two arithmetic flags come from the operands alone: carry and overflow. A third, the auxiliary (half) carry out of the low nibble, is also computed from the operands. For this the block uses a carry chain of its own. Sign, zero and parity come from the datapath result. Only the two arithmetic operations, add and subtract, produce carry, overflow and auxiliary carry. The three bitwise operations clear them.

The register captures the live flags in any cycle where the update enable is high. A masked software write takes precedence over that capture.

Top module: `alu_status_flags`

Flag vector layout, used by `flags_now`, `flags_q`, `sw_mask` and `sw_data`: bit 0 carry, bit 1 overflow, bit 2 sign, bit 3 zero, bit 4 auxiliary carry, bit 5 parity. Operation codes on `op_sel`: 0 add, 1 subtract (op_a minus op_b), 2 AND, 3 OR, 4 XOR. Codes 5 to 7 are handled like a bitwise operation.

## Requirements
- R1: For add (code 0), bit 0 is the carry out of bit 31 of op_a + op_b. For subtract (code 1), bit 0 is set exactly when op_a < op_b as unsigned values (a borrow).
- R2: For add and subtract, bit 1 is set exactly when the true signed two's-complement result does not fit in 32 bits.
- R3: Bit 2 equals result[31] for every operation code.
- R4: Bit 3 is set exactly when all 32 bits of result are zero, for every operation code.
- R5: For add, bit 4 is set when op_a[3:0] + op_b[3:0] exceeds 15. For subtract, bit 4 is set when op_a[3:0] < op_b[3:0], which is a borrow into bit 3 from bit 4.
- R6: Bit 5 is set when result[7:0] holds an even number of ones. The result bits 8 to 31 have no effect on it.
- R7: For codes 2 to 7, bits 0, 1 and 4 of flags_now are zero, whatever the operands are.
- R8: When upd_en is high and sw_wr is low, flags_q takes the value flags_now had at that clock edge. When both are low, flags_q holds.
- R9: When sw_wr is high, each flags_q bit whose sw_mask bit is 1 takes the matching sw_data bit. Each other bit keeps its value. upd_en is ignored in that cycle.
- R10: A clock edge with rst_n low clears flags_q to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (subtrahend for subtract) |
| op_sel | input | 3 | Operation code |
| result | input | 32 | Result produced by the datapath |
| upd_en | input | 1 | Capture flags_now into the register |
| sw_wr | input | 1 | Software masked write strobe |
| sw_mask | input | 6 | Bits selected by a software write |
| sw_data | input | 6 | Values for the selected bits |
| flags_now | output | 6 | Flags of the present operation |
| flags_q | output | 6 | Flags register |

## Verification
The carry-type flags are computed from the operands, while sign, zero and parity are taken from `result`. The flag vector is therefore consistent only if `result` really is the datapath's output for `op_a`, `op_b` and `op_sel`. The properties do not check that link. They only relate the decoded operation code and the register controls to the flag outputs. The bench keeps to that assumption: every stimulus derives `result` from the operands with the operation that matches `op_sel`. It changes inputs only away from the clock edge, so the register sees stable values when it captures.

// File: rtl/flag_gen_pkg.sv
// Shared constants for the status flag generator: the flag vector
// layout and the operation codes. Assumes a six-bit flag vector.
package flag_gen_pkg;
    localparam int FLAG_N = 6;
    localparam int F_CY   = 0;
    localparam int F_OV   = 1;
    localparam int F_SG   = 2;
    localparam int F_ZR   = 3;
    localparam int F_AC   = 4;
    localparam int F_PE   = 5;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } op_e;
endpackage

// File: rtl/flag_arith.sv
// Arithmetic flags (carry, overflow, auxiliary carry) computed from the
// operands with a private carry chain. Subtract runs as a + ~b + 1, and
// borrows are the inverted carries. Assumes AUX_BIT < WIDTH.
module flag_arith #(
    parameter int WIDTH   = 32,
    parameter int AUX_BIT = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             is_add,
    input  logic             is_sub,
    output logic             carry,
    output logic             ovf,
    output logic             aux
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   cch;

    // Invert the second operand and inject a carry for subtract.
    always_comb begin
        b_eff  = is_sub ? ~b : b;
        cch[0] = is_sub;
    end

    // One carry cell per bit position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign cch[i+1] = (a[i] & b_eff[i]) | ((a[i] ^ b_eff[i]) & cch[i]);
    end

    // Select flag meaning per operation; bitwise ops clear all three.
    always_comb begin
        carry = 1'b0;
        ovf   = 1'b0;
        aux   = 1'b0;
        if (is_add) begin
            carry = cch[WIDTH];
            aux   = cch[AUX_BIT];
            ovf   = cch[WIDTH] ^ cch[WIDTH-1];
        end else if (is_sub) begin
            carry = ~cch[WIDTH];
            aux   = ~cch[AUX_BIT];
            ovf   = cch[WIDTH] ^ cch[WIDTH-1];
        end
    end
endmodule

// File: rtl/flag_result.sv
// Result-derived flags: sign, zero (per-byte reduction tree) and
// even parity of the low PAR_BITS bits. Assumes WIDTH is a multiple of 8.
module flag_result #(
    parameter int WIDTH    = 32,
    parameter int PAR_BITS = 8
) (
    input  logic [WIDTH-1:0] res,
    output logic             sign,
    output logic             zero,
    output logic             par_even
);
    localparam int NBYTES = WIDTH / 8;

    logic [NBYTES-1:0] byte_nz;

    // Non-zero detect for each result byte.
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign byte_nz[k] = |res[8*k +: 8];
    end

    // Combine byte detects, copy the MSB, fold the low bits for parity.
    always_comb begin
        zero     = ~|byte_nz;
        sign     = res[WIDTH-1];
        par_even = ~^res[PAR_BITS-1:0];
    end
endmodule

// File: rtl/flag_reg.sv
// Flags register: synchronous active-low reset, then masked software
// write, then enabled capture of the live flags, in that priority.
module flag_reg #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_en,
    input  logic [N-1:0] nxt,
    input  logic         sw_wr,
    input  logic [N-1:0] sw_mask,
    input  logic [N-1:0] sw_data,
    output logic [N-1:0] q
);
    // Register update with the software write ahead of the datapath.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (sw_wr)
            q <= (q & ~sw_mask) | (sw_data & sw_mask);
        else if (upd_en)
            q <= nxt;
    end
endmodule

// File: rtl/alu_status_flags.sv
// Top of the status flag generator. Decodes the operation, joins the
// arithmetic and result flag units into one vector and registers it.
// Assumes result is the datapath output for op_a, op_b and op_sel.
module alu_status_flags
    import flag_gen_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int AUX_BIT  = 4,
    parameter int PAR_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  op_a,
    input  logic [WIDTH-1:0]  op_b,
    input  logic [2:0]        op_sel,
    input  logic [WIDTH-1:0]  result,
    input  logic              upd_en,
    input  logic              sw_wr,
    input  logic [FLAG_N-1:0] sw_mask,
    input  logic [FLAG_N-1:0] sw_data,
    output logic [FLAG_N-1:0] flags_now,
    output logic [FLAG_N-1:0] flags_q
);
    logic is_add, is_sub;
    logic cy, ov, ac, sg, zr, pe;

    // Decode the two arithmetic operation codes.
    always_comb begin
        is_add = (op_sel == OP_ADD);
        is_sub = (op_sel == OP_SUB);
    end

    flag_arith #(.WIDTH(WIDTH), .AUX_BIT(AUX_BIT)) u_arith (
        .a(op_a), .b(op_b), .is_add(is_add), .is_sub(is_sub),
        .carry(cy), .ovf(ov), .aux(ac)
    );

    flag_result #(.WIDTH(WIDTH), .PAR_BITS(PAR_BITS)) u_res (
        .res(result), .sign(sg), .zero(zr), .par_even(pe)
    );

    // Pack the flags into their vector positions.
    always_comb begin
        flags_now       = '0;
        flags_now[F_CY] = cy;
        flags_now[F_OV] = ov;
        flags_now[F_SG] = sg;
        flags_now[F_ZR] = zr;
        flags_now[F_AC] = ac;
        flags_now[F_PE] = pe;
    end

    flag_reg #(.N(FLAG_N)) u_reg (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .nxt(flags_now),
        .sw_wr(sw_wr), .sw_mask(sw_mask), .sw_data(sw_data), .q(flags_q)
    );
endmodule

// File: rtl/alu_status_flags_chk.sv
// Property checker for the status flag generator, bound to the top.
module alu_status_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] op_sel,
    input logic       upd_en,
    input logic       sw_wr,
    input logic [5:0] sw_mask,
    input logic [5:0] sw_data,
    input logic [5:0] flags_now,
    input logic [5:0] flags_q
);
    // R7
    logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= 3'd2) |-> (flags_now[0] == 1'b0 && flags_now[1] == 1'b0 && flags_now[4] == 1'b0));

    // R8
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !sw_wr) |=> (flags_q == $past(flags_now)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !sw_wr) |=> $stable(flags_q));

    // R9
    sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> (flags_q == (($past(flags_q) & ~$past(sw_mask)) | ($past(sw_data) & $past(sw_mask)))));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (flags_q == 6'd0));
endmodule

bind alu_status_flags alu_status_flags_chk u_chk (.*);

// File: tb/sim_alu_status_flags.sv
`timescale 1ns/1ps
module sim_alu_status_flags;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, result = '0;
    logic [2:0]  op_sel = '0;
    logic        upd_en = 1'b0, sw_wr = 1'b0;
    logic [5:0]  sw_mask = '0, sw_data = '0;
    logic [5:0]  flags_now, flags_q;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    alu_status_flags u0 (.*);

    // Datapath result for an operation code.
    function automatic logic [31:0] dp_res(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            default: return a ^ b;
        endcase
    endfunction

    // Expected flag vector from the requirements.
    function automatic logic [5:0] model(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
        logic [5:0] f;
        logic [32:0] u;
        longint s;
        logic [31:0] r;
        r = dp_res(a, b, op);
        f = '0;
        if (op == 3'd0) begin
            u = {1'b0, a} + {1'b0, b};
            f[0] = u[32];
            s = longint'($signed(a)) + longint'($signed(b));
            f[1] = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            f[4] = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
        end else if (op == 3'd1) begin
            f[0] = a < b;
            s = longint'($signed(a)) - longint'($signed(b));
            f[1] = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            f[4] = a[3:0] < b[3:0];
        end
        f[2] = r[31];
        f[3] = (r == 32'd0);
        f[5] = ($countones(r[7:0]) % 2) == 0;
        return f;
    endfunction

    task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
        @(negedge clk);
        op_a = a; op_b = b; op_sel = op; result = dp_res(a, b, op);
        #1;
    endtask

    task automatic live(input string req, input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
        drive(a, b, op);
        check(req, flags_now, model(a, b, op));
    endtask

    task automatic t_reset();
        @(negedge clk); @(negedge clk);
        check("R10 reset", flags_q, 6'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_add();
        live("R1 R5 carry+aux 0xFFFFFFFF+1", 32'hFFFF_FFFF, 32'h1, 3'd0);
        check("R1 R4 explicit", flags_now, 6'b111001);
        live("R2 overflow 0x7FFFFFFF+1", 32'h7FFF_FFFF, 32'h1, 3'd0);
        check("R2 R3 explicit", flags_now, 6'b110110);
        live("R2 neg overflow", 32'h8000_0000, 32'h8000_0000, 3'd0);
        live("R5 nibble 0x0F+0x01", 32'h0000_000F, 32'h1, 3'd0);
        live("R1 plain add", 32'h1234_5678, 32'h1111_1111, 3'd0);
    endtask

    task automatic t_sub();
        live("R1 borrow 0-1", 32'h0, 32'h1, 3'd1);
        check("R1 R5 explicit", flags_now, 6'b110101);
        live("R2 sub overflow", 32'h8000_0000, 32'h1, 3'd1);
        live("R4 equal sub", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'd1);
        live("R5 nibble borrow", 32'h0000_0010, 32'h1, 3'd1);
    endtask

    task automatic t_logic();
        live("R7 and", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd2);
        check("R7 and explicit", flags_now, 6'b100100);
        live("R7 or", 32'h8000_000F, 32'h7FFF_FFF1, 3'd3);
        live("R7 xor zero", 32'hA5A5_A5A5, 32'hA5A5_A5A5, 3'd4);
        live("R7 code 6", 32'hFFFF_FFFF, 32'h0000_0001, 3'd6);
    endtask

    task automatic t_parity();
        live("R6 odd low byte", 32'hFFFF_FF00, 32'h0000_0001, 3'd3);
        check("R6 upper ignored", flags_now[5], 1'b0);
        live("R6 even low byte", 32'h0000_0003, 32'h0, 3'd3);
        check("R6 even", flags_now[5], 1'b1);
    endtask

    task automatic t_reg();
        logic [5:0] held;
        drive(32'hFFFF_FFFF, 32'h1, 3'd0);
        upd_en = 1'b1;
        @(negedge clk);
        upd_en = 1'b0;
        #1;
        check("R8 capture", flags_q, 6'b111001);
        held = flags_q;
        drive(32'h0, 32'h1, 3'd1);
        @(negedge clk); #1;
        check("R8 hold", flags_q, held);
        // Masked write with upd_en also high: write wins.
        @(negedge clk);
        sw_wr = 1'b1; upd_en = 1'b1; sw_mask = 6'b000011; sw_data = 6'b000010;
        @(negedge clk);
        sw_wr = 1'b0; upd_en = 1'b0;
        #1;
        check("R9 masked write", flags_q, 6'b111010);
        @(negedge clk);
        sw_wr = 1'b1; sw_mask = 6'b100000; sw_data = 6'b000000;
        @(negedge clk);
        sw_wr = 1'b0;
        #1;
        check("R9 clear one bit", flags_q, 6'b011010);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 reset again", flags_q, 6'd0);
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_parity();
        t_reg();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule